// File: doc/BRIEF.md
# Three-Channel Reloadable Countdown Timer

This peripheral holds three 32-bit down-counters behind a small memory-mapped register bus with separate read and write strobes. Each channel has a reload value, a live count and a 16-bit control word. The control word selects a prescaled count clock, enables the channel's interrupt and holds a sticky underflow flag. A shared start register runs or freezes each channel on its own.

Software loads a reload value and a starting count, picks a prescale code and sets the channel's start bit. The counter steps down once per prescaled tick. On the tick that finds it at zero, it reloads and raises its flag. Software acknowledges the event by writing the control word with the flag bit low. Reads are combinational and return data in the cycle in which `rd_en_i` is high. Writes take effect at the clock edge that samples `wr_en_i`.

Top module: `tmr_top`

## Requirements
- R1: After reset, the output-control byte (offset 0x00) and the start byte (0x04) read 0. Every reload register reads 0xFFFFFFFF, every counter reads 0xFFFFFFFF, every control word reads 0, and `irq_o` is 0.
- R2: Bit n of the start byte (n = 0..2) runs channel n. A channel whose bit is clear keeps its count unchanged.
- R3: Each channel has its own prescaler, which is cleared while the channel is stopped. With prescale code c (control bits 2:0, c = 0..4), the counter steps down by one at the edge 4·4^c cycles after the edge that wrote the start bit, and then once every 4·4^c cycles.
- R4: A tick that finds the counter at 0 loads the channel's reload register into the counter and sets the underflow flag (control bit 8). Counting then goes on from the reloaded value.
- R5: `irq_o[n]` is 1 exactly one cycle after control bit 8 and control bit 5 (interrupt enable) are both 1. It is 0 one cycle after either of them is 0.
- R6: A control write copies its bit 8 into the flag, so writing 0 clears the flag. If the write lands on the same edge as an underflow, the flag still ends up 1. The flag otherwise stays set until software clears it.
- R7: Prescale codes 5, 6 and 7 produce no ticks, so a running channel with one of these codes holds its count.
- R8: Changing the prescale code keeps the present count. The new rate applies from the prescaler's current phase.
- R9: A counter write loads the written value at any time. If it lands on a tick edge, the written value is kept and that tick is dropped. Counting continues down from the written value.
- R10: Register map, using byte offsets on `addr_i`: channel n has its reload register at 0x08+12n, its counter at 0x0C+12n and its control word at 0x10+12n. Control reads return bits 15:9, 7:6 and 4:3 as 0. Offsets 0x00 and 0x04 store 8 bits. Offset 0x2C and any unmapped offset read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when `rd_en_i` is low |
| irq_o | output | 3 | Underflow interrupt per channel |

## Verification
The bench times the first decrement after a start for every supported prescale code. A design that did not clear its prescaler on start, or that decoded the divider off by one code, would decrement early or late. It runs a channel through several full reload cycles against an arithmetic model, checking the count, flag and interrupt every cycle. Missing reloads, a flag that is not sticky, or an interrupt without its one-cycle delay would show up as a mismatch. It places bus writes on exact tick and underflow edges. A counter write that lost to the tick, or a flag clear that beat the hardware set, would leave a wrong value. It also switches the prescale rate mid-count and parks channels on the unsupported codes, so a design that reset the count on a rate change or kept counting on those codes would fail.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_CH    = 3;
  localparam int unsigned OFS_OUTCTL = 0;
  localparam int unsigned OFS_START  = 4;
  localparam int unsigned OFS_CH0    = 8;
  localparam int unsigned CH_STRIDE  = 12;
  localparam int unsigned SLOT_RLD   = 0;
  localparam int unsigned SLOT_CNT   = 4;
  localparam int unsigned SLOT_CTL   = 8;
  localparam int unsigned FLAG_BIT   = 8;
  localparam int unsigned IE_BIT     = 5;
  localparam int unsigned CODE_W     = 3;
  localparam int unsigned MAX_CODE   = 4;
  localparam int unsigned CTL_W      = 16;

  typedef struct packed {
    logic              flag;
    logic              ie;
    logic [CODE_W-1:0] code;
  } ctl_t;

  function automatic logic [CTL_W-1:0] ctl_pack(ctl_t c);
    logic [CTL_W-1:0] r;
    r = '0;
    r[FLAG_BIT]   = c.flag;
    r[IE_BIT]     = c.ie;
    r[CODE_W-1:0] = c.code;
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned PSC_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] mask;
  logic             code_ok;

  // held at zero while stopped, so the first tick is a full period after start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    mask    = ~({PSC_W{1'b1}} << (2 * int'(code_i) + 2));
    code_ok = (code_i <= CODE_W'(MAX_CODE));
  end

  assign tick_o = run_i && code_ok && ((cnt_q & mask) == mask);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PSC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_rld_i,
  input  logic             wr_cnt_i,
  input  logic             wr_ctl_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rld_o,
  output logic [CNT_W-1:0] cnt_o,
  output ctl_t             ctl_o,
  output logic             tick_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] rld_q, cnt_q;
  ctl_t             ctl_q;
  logic             tick, uf, flag_nxt, irq_q;

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .code_i (ctl_q.code),
    .tick_o (tick)
  );

  assign uf = tick && !wr_cnt_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rld_q <= '1;
    else if (wr_rld_i) rld_q <= wdata_i;
  end

  // bus write beats the tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '1;
    else if (wr_cnt_i) cnt_q <= wdata_i;
    else if (uf)       cnt_q <= rld_q;
    else if (tick)     cnt_q <= cnt_q - 1'b1;
  end

  // hardware set beats a software clear
  always_comb flag_nxt = (wr_ctl_i ? wdata_i[FLAG_BIT] : ctl_q.flag) | uf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      ctl_q.flag <= flag_nxt;
      if (wr_ctl_i) begin
        ctl_q.ie   <= wdata_i[IE_BIT];
        ctl_q.code <= wdata_i[CODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= ctl_q.flag & ctl_q.ie;
  end

  assign rld_o  = rld_q;
  assign cnt_o  = cnt_q;
  assign ctl_o  = ctl_q;
  assign tick_o = tick;
  assign irq_o  = irq_q;
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 10,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [BYTE_W-1:0] outctl_q, start_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  rld_w, cnt_w;
  ctl_t [NUM_CH-1:0]             ctl_w;
  logic [NUM_CH-1:0]             tick_w, wr_cnt_w, wr_ctl_w, flag_w, ie_w;
  logic [NUM_CH-1:0][CODE_W-1:0] code_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outctl_q <= '0;
      start_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(OFS_OUTCTL)) outctl_q <= wdata_i[BYTE_W-1:0];
      if (addr_i == ADDR_W'(OFS_START))  start_q  <= wdata_i[BYTE_W-1:0];
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int unsigned BASE = OFS_CH0 + CH_STRIDE * n;
    logic wr_rld;
    assign wr_rld      = wr_en_i && (addr_i == ADDR_W'(BASE + SLOT_RLD));
    assign wr_cnt_w[n] = wr_en_i && (addr_i == ADDR_W'(BASE + SLOT_CNT));
    assign wr_ctl_w[n] = wr_en_i && (addr_i == ADDR_W'(BASE + SLOT_CTL));

    tmr_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (start_q[n]),
      .wr_rld_i (wr_rld),
      .wr_cnt_i (wr_cnt_w[n]),
      .wr_ctl_i (wr_ctl_w[n]),
      .wdata_i  (wdata_i),
      .rld_o    (rld_w[n]),
      .cnt_o    (cnt_w[n]),
      .ctl_o    (ctl_w[n]),
      .tick_o   (tick_w[n]),
      .irq_o    (irq_o[n])
    );

    assign flag_w[n] = ctl_w[n].flag;
    assign ie_w[n]   = ctl_w[n].ie;
    assign code_w[n] = ctl_w[n].code;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == ADDR_W'(OFS_OUTCTL)) rdata_o = CNT_W'(outctl_q);
      if (addr_i == ADDR_W'(OFS_START))  rdata_o = CNT_W'(start_q);
      for (int n = 0; n < NUM_CH; n++) begin
        if (addr_i == ADDR_W'(OFS_CH0 + CH_STRIDE * n + SLOT_RLD)) rdata_o = rld_w[n];
        if (addr_i == ADDR_W'(OFS_CH0 + CH_STRIDE * n + SLOT_CNT)) rdata_o = cnt_w[n];
        if (addr_i == ADDR_W'(OFS_CH0 + CH_STRIDE * n + SLOT_CTL)) rdata_o = CNT_W'(ctl_pack(ctl_w[n]));
      end
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_CH-1:0]             run_i,
  input logic [NUM_CH-1:0]             tick_i,
  input logic [NUM_CH-1:0]             wr_cnt_i,
  input logic [NUM_CH-1:0]             wr_ctl_i,
  input logic [CNT_W-1:0]              wdata_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]  rld_i,
  input logic [NUM_CH-1:0]             flag_i,
  input logic [NUM_CH-1:0]             ie_i,
  input logic [NUM_CH-1:0][CODE_W-1:0] code_i,
  input logic [NUM_CH-1:0]             irq_i
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i[n] && !wr_cnt_i[n]) |=> $stable(cnt_i[n])); // R2
    AST_TICK_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i[n] && !wr_cnt_i[n] && cnt_i[n] != '0) |=> cnt_i[n] == CNT_W'($past(cnt_i[n]) - 1'b1)); // R3
    AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i[n] && !wr_cnt_i[n] && cnt_i[n] == '0) |=> (cnt_i[n] == $past(rld_i[n])) && flag_i[n]); // R4
    AST_IRQ_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[n] && ie_i[n]) |=> irq_i[n]); // R5
    AST_IRQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(flag_i[n] && ie_i[n]) |=> !irq_i[n]); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[n] && !wr_ctl_i[n]) |=> flag_i[n]); // R6
    AST_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_i[n] > CODE_W'(MAX_CODE)) |-> !tick_i[n]); // R7
    AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_cnt_i[n] |=> cnt_i[n] == $past(wdata_i)); // R9
  end
endmodule

bind tmr_top tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (start_q[NUM_CH-1:0]),
  .tick_i   (tick_w),
  .wr_cnt_i (wr_cnt_w),
  .wr_ctl_i (wr_ctl_w),
  .wdata_i  (wdata_i),
  .cnt_i    (cnt_w),
  .rld_i    (rld_w),
  .flag_i   (flag_w),
  .ie_i     (ie_w),
  .code_i   (code_w),
  .irq_i    (irq_o)
);

// File: tb/tmr_top_tb.sv
`timescale 1ns/1ps
module tmr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int n_total = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tmr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [5:0] a_rld(int n); return 6'(8 + 12 * n);  endfunction
  function automatic logic [5:0] a_cnt(int n); return 6'(12 + 12 * n); endfunction
  function automatic logic [5:0] a_ctl(int n); return 6'(16 + 12 * n); endfunction

  task automatic step(int k);
    for (int i = 0; i < k; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #0.5 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(string req, logic [5:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    #(200000 * 5);
    n_total++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int m_cnt, m_flag, m_irq, div;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(1);

    // R1 reset values
    chk_reg("R1 outctl", 6'h00, 32'h0);
    chk_reg("R1 start",  6'h04, 32'h0);
    for (int n = 0; n < 3; n++) begin
      chk_reg("R1 reload", a_rld(n), 32'hFFFF_FFFF);
      chk_reg("R1 count",  a_cnt(n), 32'hFFFF_FFFF);
      chk_reg("R1 ctl",    a_ctl(n), 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);

    // R10 map, storage, capture slot, ctl read mask
    wr(6'h00, 32'hFFFF_FFA5); chk_reg("R10 outctl", 6'h00, 32'hA5);
    wr(6'h04, 32'h0000_00F8); chk_reg("R10 start",  6'h04, 32'hF8);
    wr(6'h04, 32'h0);
    for (int n = 0; n < 3; n++) wr(a_rld(n), 32'h1000 + 32'(n));
    for (int n = 0; n < 3; n++) chk_reg("R10 reload per channel", a_rld(n), 32'h1000 + 32'(n));
    wr(6'h2C, 32'h1234_5678); chk_reg("R10 capture reads zero", 6'h2C, 32'h0);
    wr(a_ctl(1), 32'hFFFF_FFFF); chk_reg("R10 ctl mask", a_ctl(1), 32'h0000_0127);
    wr(a_ctl(1), 32'h0); chk_reg("R10 ctl clear", a_ctl(1), 32'h0);

    // R2 only channel 1 runs
    for (int n = 0; n < 3; n++) wr(a_cnt(n), 32'd10);
    wr(6'h04, 32'h2);
    step(40);
    chk_reg("R2 ch0 held", a_cnt(0), 32'd10);
    chk_reg("R2 ch1 ran",  a_cnt(1), 32'd0);
    chk_reg("R2 ch2 held", a_cnt(2), 32'd10);
    wr(6'h04, 32'h0);

    // R3 first decrement timing per prescale code
    for (int c = 0; c <= 4; c++) begin
      div = 4 << (2 * c);
      wr(a_ctl(2), 32'(c));
      wr(a_cnt(2), 32'd1000);
      wr(6'h04, 32'h4);
      step(div - 1);
      chk_reg("R3 before first tick", a_cnt(2), 32'd1000);
      step(1);
      chk_reg("R3 first tick", a_cnt(2), 32'd999);
      step(div - 1);
      chk_reg("R3 before second tick", a_cnt(2), 32'd999);
      step(1);
      chk_reg("R3 second tick", a_cnt(2), 32'd998);
      wr(6'h04, 32'h0);
    end

    // R4/R5 reload loop against model, ie on, code 0
    wr(a_rld(0), 32'd2);
    wr(a_cnt(0), 32'd1);
    wr(a_ctl(0), 32'h20);
    wr(6'h04, 32'h1);
    m_cnt = 1; m_flag = 0; m_irq = 0;
    for (int k = 1; k <= 40; k++) begin
      step(1);
      m_irq = m_flag;
      if (k % 4 == 0) begin
        if (m_cnt == 0) begin m_cnt = 2; m_flag = 1; end
        else m_cnt--;
      end
      chk_reg("R4 count", a_cnt(0), 32'(m_cnt));
      rd(a_ctl(0), d);
      chk("R4 flag", 32'(d[8]), 32'(m_flag));
      chk("R5 irq", 32'(irq[0]), 32'(m_irq));
    end
    wr(6'h04, 32'h0);
    wr(a_ctl(0), 32'h0);
    step(1);
    chk("R5 irq drops", 32'(irq[0]), 32'h0);

    // R6 clear colliding with underflow: hardware set wins
    wr(a_rld(0), 32'd7);
    wr(a_cnt(0), 32'd0);
    wr(a_ctl(0), 32'h20);
    wr(6'h04, 32'h1);        // P0
    step(3);
    wr(a_ctl(0), 32'h20);    // lands on P0+4, underflow edge
    rd(a_ctl(0), d);
    chk("R6 set wins", 32'(d[8]), 32'h1);
    chk_reg("R4 reload on collide", a_cnt(0), 32'd7);
    wr(a_ctl(0), 32'h20);    // P0+5, clear
    rd(a_ctl(0), d);
    chk("R6 clear", 32'(d[8]), 32'h0);
    chk("R5 irq one cycle late", 32'(irq[0]), 32'h1);
    step(1);
    chk("R6 irq dropped", 32'(irq[0]), 32'h0);
    wr(6'h04, 32'h0);
    wr(a_ctl(0), 32'h0);

    // R7 unsupported codes hold
    for (int c = 5; c <= 7; c++) begin
      wr(a_ctl(0), 32'(c));
      wr(a_cnt(0), 32'd33);
      wr(6'h04, 32'h1);
      step(1100);
      chk_reg("R7 no count", a_cnt(0), 32'd33);
      wr(6'h04, 32'h0);
    end
    wr(a_ctl(0), 32'h0);

    // R8 rate change mid-count
    wr(a_ctl(2), 32'h0);
    wr(a_cnt(2), 32'd100);
    wr(6'h04, 32'h4);        // P0
    step(5);
    chk_reg("R8 before switch", a_cnt(2), 32'd99);
    wr(a_ctl(2), 32'h1);     // P0+6
    chk_reg("R8 count kept", a_cnt(2), 32'd99);
    step(9);
    chk_reg("R8 no early tick", a_cnt(2), 32'd99);
    step(1);
    chk_reg("R8 new rate", a_cnt(2), 32'd98);
    wr(6'h04, 32'h0);

    // R9 counter write on a tick edge
    wr(a_ctl(1), 32'h0);
    wr(a_cnt(1), 32'd50);
    wr(6'h04, 32'h2);        // P0
    step(3);
    wr(a_cnt(1), 32'd20);    // P0+4 tick edge
    chk_reg("R9 write wins", a_cnt(1), 32'd20);
    step(3);
    chk_reg("R9 held to next tick", a_cnt(1), 32'd20);
    step(1);
    chk_reg("R9 continues down", a_cnt(1), 32'd19);
    wr(6'h04, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule